// File: doc/BRIEF.md
# Configuration Port Sequencer

This block drives an on-chip configuration access port of the kind with two separate 8-bit data buses (one into the port, one out of it), an enable, a direction select and a stall input. A controlling block sets an operation type and a frame address and pulses `start`. The sequencer then runs one complete frame transfer against the port. It can run a writeback, which sends a frame taken from a byte-addressed frame buffer. It can also run a readback, which collects a frame from the port into that buffer. It pulses `done` when the transfer is finished.

Every operation runs the same five steps in a fixed order: a synchronisation word, a command word followed by the frame address, the frame bytes, one flush (dummy) frame of the same length, and a desynchronisation word. The sync, command and desync words are parameters. They are held in a small header table and sent most significant byte first. The port moves one byte on a rising edge only while the enable is high and the stall input is low. During a stall the sequencer holds the byte it offers, the direction and the buffer address. The frame buffer is external, with a synchronous read port that has a read enable. The sequencer prefetches one byte ahead, so writeback frame bytes flow with no gap cycles.

Top module: `cfg_port_seq`

## Requirements
- R1: After reset, `cp_en` is 0, `cp_wr` is 1, `done` is 0 and `fb_we` is 0.
- R2: A writeback (`op_rd`=0) sends these bytes to the port, in order, with each 32-bit word most significant byte first: SYNC_WORD, CMD_WR_WORD, the frame address, buffer bytes 0 to FRAME_LEN-1 in address order, FRAME_LEN zero bytes, and DESYNC_WORD. That totals 16+2*FRAME_LEN transfers.
- R3: A readback (`op_rd`=1) writes exactly SYNC_WORD, CMD_RD_WORD, the frame address and DESYNC_WORD to the port (16 bytes). Between the address and the desync word, `cp_wr` is 0 and exactly 2*FRAME_LEN bytes are read. `cp_wr` is never 0 while `cp_en` is 0.
- R4: During a readback, the first FRAME_LEN bytes read are stored at buffer addresses 0 to FRAME_LEN-1 in order. The dummy-frame bytes are never written, so `fb_we` is high for exactly FRAME_LEN cycles. `fb_we` is only high while the port is enabled in read direction.
- R5: A byte moves only on an edge where `cp_en`=1 and `cp_busy`=0. While `cp_busy` is high, `cp_wdata`, `cp_wr` and `fb_addr` keep their values into the next cycle.
- R6: `done` is high for exactly one cycle, in the cycle after the edge that moves the last desync byte. `cp_en` is 0 in that cycle.
- R7: A `start` pulse while an operation is running is ignored. The running byte stream is unchanged and only one `done` follows.
- R8: `op_rd` and `frame_addr` are sampled only when `start` is accepted. Changing them later has no effect on the running operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| op_rd | input | 1 | 1 = readback, 0 = writeback |
| frame_addr | input | WORD_W | Frame address sent after the command word |
| done | output | 1 | One-cycle completion pulse |
| cp_en | output | 1 | Port enable |
| cp_wr | output | 1 | Port direction: 1 = write into port, 0 = read from port |
| cp_wdata | output | 8 | Byte into the port |
| cp_rdata | input | 8 | Byte out of the port |
| cp_busy | input | 1 | Port stall; no transfer while high |
| fb_addr | output | AW | Frame buffer byte address |
| fb_re | output | 1 | Frame buffer read enable |
| fb_we | output | 1 | Frame buffer write enable |
| fb_wdata | output | 8 | Byte written to the frame buffer |
| fb_rdata | input | 8 | Frame buffer read data, one cycle after `fb_re` |

## Verification
The checker watches several rules on every cycle. It checks that the offered byte, the direction and the buffer address freeze across a stall. It checks that buffer writes happen only in read direction with the port enabled, and that read direction never appears while the port is idle. It also checks that `done` is a single-cycle pulse that coincides with an idle port. Other behaviour depends on a whole operation and can only be shown by the bench scenarios. This covers the exact order and content of the byte stream, the prefetched buffer bytes reaching the port without gaps, the dummy frame being dropped on readback, and a mid-operation `start` or address change being ignored. These scenarios are run under several stall patterns.

// File: rtl/cps_pkg.sv
package cps_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SYNC,
    PH_CMD,
    PH_ADDR,
    PH_DATA,
    PH_DUMMY,
    PH_DESYNC
  } phase_e;

  // Step order of one operation; after desync the sequencer returns to idle.
  function automatic phase_e phase_after(input phase_e p);
    case (p)
      PH_SYNC:  return PH_CMD;
      PH_CMD:   return PH_ADDR;
      PH_ADDR:  return PH_DATA;
      PH_DATA:  return PH_DUMMY;
      PH_DUMMY: return PH_DESYNC;
      default:  return PH_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/cps_hdr_rom.sv
module cps_hdr_rom
  import cps_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter logic [WORD_W-1:0] SYNC_WORD   = 32'h5AC3_0F96,
  parameter logic [WORD_W-1:0] CMD_RD_WORD = 32'h2800_4001,
  parameter logic [WORD_W-1:0] CMD_WR_WORD = 32'h3000_8002,
  parameter logic [WORD_W-1:0] DESYNC_WORD = 32'h0D0D_A5A5,
  localparam int WB = WORD_W / 8,
  localparam int IW = (WB > 1) ? $clog2(WB) : 1
) (
  input  phase_e            phase,
  input  logic [IW-1:0]     idx,
  input  logic              op_rd,
  input  logic [WORD_W-1:0] frame_addr,
  output logic [7:0]        hdr_byte
);

  logic [WORD_W-1:0] word;
  logic [7:0]        lane [WB];

  always_comb begin
    case (phase)
      PH_SYNC:   word = SYNC_WORD;
      PH_CMD:    word = op_rd ? CMD_RD_WORD : CMD_WR_WORD;
      PH_ADDR:   word = frame_addr;
      PH_DESYNC: word = DESYNC_WORD;
      default:   word = '0;
    endcase
  end

  // lane[b] is the b-th byte on the wire: most significant first
  for (genvar b = 0; b < WB; b++) begin : g_lane
    assign lane[b] = word[(WB-1-b)*8 +: 8];
  end

  assign hdr_byte = lane[idx];

endmodule

// File: rtl/cps_seq_fsm.sv
module cps_seq_fsm
  import cps_pkg::*;
#(
  parameter int FRAME_LEN = 824,
  parameter int WB        = 4,
  localparam int CW = $clog2(FRAME_LEN)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_acc,
  input  logic          xfer,
  output phase_e        phase,
  output logic [CW-1:0] cnt,
  output logic          last,
  output logic          done
);

  localparam logic [CW-1:0] FR_LAST = CW'(FRAME_LEN - 1);
  localparam logic [CW-1:0] WD_LAST = CW'(WB - 1);

  always_comb begin
    if (phase == PH_DATA || phase == PH_DUMMY) last = (cnt == FR_LAST);
    else                                        last = (cnt == WD_LAST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (phase == PH_IDLE) begin
        if (start_acc) begin
          phase <= PH_SYNC;
          cnt   <= '0;
        end
      end else if (xfer) begin
        if (last) begin
          cnt   <= '0;
          phase <= phase_after(phase);
          if (phase == PH_DESYNC) done <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/cps_fb_port.sv
module cps_fb_port
  import cps_pkg::*;
#(
  parameter int FRAME_LEN = 824,
  localparam int CW = $clog2(FRAME_LEN),
  localparam int AW = $clog2(FRAME_LEN)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_acc,
  input  logic          op_rd,
  input  phase_e        phase,
  input  logic [CW-1:0] cnt,
  input  logic          last,
  input  logic          xfer,
  input  logic [7:0]    rd_byte,
  output logic [AW-1:0] fb_addr,
  output logic          fb_we,
  output logic [7:0]    fb_wdata
);

  // Writeback: while byte k is offered, fb_addr already points at k+1,
  // so the synchronous buffer read lands exactly when byte k is consumed.
  logic nxt_in_frame;
  assign nxt_in_frame = (int'(cnt) + 2) < FRAME_LEN;

  always_ff @(posedge clk) begin
    if (rst) begin
      fb_addr  <= '0;
      fb_we    <= 1'b0;
      fb_wdata <= '0;
    end else begin
      fb_we <= 1'b0;
      if (start_acc) begin
        fb_addr <= '0;
      end else if (op_rd) begin
        if (xfer && phase == PH_DATA) begin
          fb_we    <= 1'b1;
          fb_wdata <= rd_byte;
          fb_addr  <= AW'(cnt);
        end
      end else if (xfer) begin
        if (phase == PH_ADDR && last)
          fb_addr <= AW'(1);
        else if (phase == PH_DATA && nxt_in_frame)
          fb_addr <= AW'(int'(cnt) + 2);
      end
    end
  end

endmodule

// File: rtl/cfg_port_seq.sv
module cfg_port_seq
  import cps_pkg::*;
#(
  parameter int FRAME_LEN = 824,
  parameter int WORD_W    = 32,
  parameter logic [WORD_W-1:0] SYNC_WORD   = 32'h5AC3_0F96,
  parameter logic [WORD_W-1:0] CMD_RD_WORD = 32'h2800_4001,
  parameter logic [WORD_W-1:0] CMD_WR_WORD = 32'h3000_8002,
  parameter logic [WORD_W-1:0] DESYNC_WORD = 32'h0D0D_A5A5,
  localparam int WB = WORD_W / 8,
  localparam int IW = (WB > 1) ? $clog2(WB) : 1,
  localparam int CW = $clog2(FRAME_LEN),
  localparam int AW = $clog2(FRAME_LEN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              op_rd,
  input  logic [WORD_W-1:0] frame_addr,
  output logic              done,
  output logic              cp_en,
  output logic              cp_wr,
  output logic [7:0]        cp_wdata,
  input  logic [7:0]        cp_rdata,
  input  logic              cp_busy,
  output logic [AW-1:0]     fb_addr,
  output logic              fb_re,
  output logic              fb_we,
  output logic [7:0]        fb_wdata,
  input  logic [7:0]        fb_rdata
);

  phase_e            phase;
  logic [CW-1:0]     cnt;
  logic              last;
  logic              xfer;
  logic              start_acc;
  logic              op_rd_q;
  logic [WORD_W-1:0] addr_q;
  logic [7:0]        hdr_byte;
  logic              in_frame;

  assign start_acc = start && (phase == PH_IDLE);
  assign cp_en     = (phase != PH_IDLE);
  assign xfer      = cp_en && !cp_busy;
  assign in_frame  = (phase == PH_DATA) || (phase == PH_DUMMY);
  assign cp_wr     = !(op_rd_q && in_frame);
  assign fb_re     = xfer && !op_rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      op_rd_q <= 1'b0;
      addr_q  <= '0;
    end else if (start_acc) begin
      op_rd_q <= op_rd;
      addr_q  <= frame_addr;
    end
  end

  always_comb begin
    if (phase == PH_DATA)       cp_wdata = op_rd_q ? 8'h00 : fb_rdata;
    else if (phase == PH_DUMMY) cp_wdata = 8'h00;
    else                        cp_wdata = hdr_byte;
  end

  cps_seq_fsm #(.FRAME_LEN(FRAME_LEN), .WB(WB)) u_fsm (
    .clk(clk), .rst(rst), .start_acc(start_acc), .xfer(xfer),
    .phase(phase), .cnt(cnt), .last(last), .done(done)
  );

  cps_hdr_rom #(
    .WORD_W(WORD_W), .SYNC_WORD(SYNC_WORD), .CMD_RD_WORD(CMD_RD_WORD),
    .CMD_WR_WORD(CMD_WR_WORD), .DESYNC_WORD(DESYNC_WORD)
  ) u_rom (
    .phase(phase), .idx(cnt[IW-1:0]), .op_rd(op_rd_q),
    .frame_addr(addr_q), .hdr_byte(hdr_byte)
  );

  cps_fb_port #(.FRAME_LEN(FRAME_LEN)) u_fb (
    .clk(clk), .rst(rst), .start_acc(start_acc), .op_rd(op_rd_q),
    .phase(phase), .cnt(cnt), .last(last), .xfer(xfer),
    .rd_byte(cp_rdata), .fb_addr(fb_addr), .fb_we(fb_we), .fb_wdata(fb_wdata)
  );

endmodule

// File: rtl/cfg_port_seq_chk.sv
module cfg_port_seq_chk #(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          cp_en,
  input logic          cp_busy,
  input logic          cp_wr,
  input logic [7:0]    cp_wdata,
  input logic [AW-1:0] fb_addr,
  input logic          fb_we,
  input logic          done
);

  a_r5_hold_on_busy: assert property (@(posedge clk) disable iff (rst)
    (cp_en && cp_busy) |=> ($stable(cp_wdata) && $stable(cp_wr) && $stable(fb_addr)));

  a_r4_store_only_reading: assert property (@(posedge clk) disable iff (rst)
    fb_we |-> (cp_en && !cp_wr));

  a_r3_read_needs_enable: assert property (@(posedge clk) disable iff (rst)
    !cp_wr |-> cp_en);

  a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r6_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !cp_en);

endmodule

bind cfg_port_seq cfg_port_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .cp_en(cp_en), .cp_busy(cp_busy), .cp_wr(cp_wr),
  .cp_wdata(cp_wdata), .fb_addr(fb_addr), .fb_we(fb_we), .done(done)
);

// File: tb/cfg_port_seq_bench.sv
`timescale 1ns/1ps
module cfg_port_seq_bench;
  localparam int FL = 824;
  localparam int AW = $clog2(FL);
  localparam logic [31:0] SYNC_W = 32'h5AC3_0F96;
  localparam logic [31:0] CMDR_W = 32'h2800_4001;
  localparam logic [31:0] CMDW_W = 32'h3000_8002;
  localparam logic [31:0] DSYN_W = 32'h0D0D_A5A5;

  logic clk = 0, rst = 1, start = 0, op_rd = 0;
  logic [31:0] frame_addr = '0;
  logic done, cp_en, cp_wr, cp_busy = 0, fb_re, fb_we;
  logic [7:0] cp_wdata, cp_rdata, fb_wdata, fb_rdata = '0;
  logic [AW-1:0] fb_addr;

  always #2 clk = ~clk;

  cfg_port_seq u_cfg_port_seq (
    .clk(clk), .rst(rst), .start(start), .op_rd(op_rd), .frame_addr(frame_addr),
    .done(done), .cp_en(cp_en), .cp_wr(cp_wr), .cp_wdata(cp_wdata),
    .cp_rdata(cp_rdata), .cp_busy(cp_busy), .fb_addr(fb_addr), .fb_re(fb_re),
    .fb_we(fb_we), .fb_wdata(fb_wdata), .fb_rdata(fb_rdata)
  );

  int n_tests = 0, n_fail = 0;
  int wn = 0, rn = 0, we_cnt = 0, cyc = 0, busy_mode = 0;
  int done_cnt = 0, done_wide = 0, done_en = 0, done_early = 0, hold_err = 0;
  int exp_wn = 0;
  logic [7:0] wlog [8192];
  logic [7:0] mem [FL];

  function automatic logic [7:0] rd_pat(input int n);
    return 8'((n * 37) + (n >> 3) + 5);
  endfunction
  assign cp_rdata = rd_pat(rn);

  // frame buffer model: synchronous read with enable
  always @(posedge clk) begin
    if (fb_re) fb_rdata <= mem[fb_addr];
    if (fb_we) begin mem[fb_addr] = fb_wdata; we_cnt = we_cnt + 1; end
  end

  // port model: sample at falling edge, commit after the rising edge
  logic pend = 0, pend_wr = 0, prev_stall = 0, prev_done = 0;
  logic [7:0] pend_din = '0, p_din = '0;
  logic p_wr = 0;
  logic [AW-1:0] p_addr = '0;

  always @(negedge clk) begin
    if (!rst) begin
      if (prev_stall && (cp_wdata != p_din || cp_wr != p_wr || fb_addr != p_addr))
        hold_err = hold_err + 1;
      if (done) begin
        done_cnt = done_cnt + 1;
        if (cp_en) done_en = done_en + 1;
        if (prev_done) done_wide = done_wide + 1;
        if (wn != exp_wn) done_early = done_early + 1;
      end
    end
    pend = cp_en && !cp_busy; pend_wr = cp_wr; pend_din = cp_wdata;
    prev_stall = cp_en && cp_busy; p_din = cp_wdata; p_wr = cp_wr; p_addr = fb_addr;
    prev_done = done;
  end

  initial forever begin
    @(posedge clk); #1;
    if (pend) begin
      if (pend_wr) begin wlog[wn % 8192] = pend_din; wn = wn + 1; end
      else rn = rn + 1;
    end
    case (busy_mode)
      1:       cp_busy = (cyc % 3) == 2;
      2:       cp_busy = (cyc % 11) < 5;
      default: cp_busy = 1'b0;
    endcase
    cyc = cyc + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] wbyte(input logic [31:0] w, input int i);
    return w[(3-i)*8 +: 8];
  endfunction

  // launch an operation and wait for completion
  task automatic run_op(input bit rd, input logic [31:0] a, input int exp_bytes,
                        input bit poke, output bit ok);
    int t;
    exp_wn = wn + exp_bytes;
    @(posedge clk); #1; start = 1; op_rd = rd; frame_addr = a;
    @(posedge clk); #1; start = 0; op_rd = !rd; frame_addr = ~a;   // R8: late changes
    if (poke) begin
      repeat (30) @(posedge clk);
      #1; start = 1; @(posedge clk); #1; start = 0;                // R7: ignored start
    end
    t = 0;
    while (done_cnt == 0 && t < 20000) begin @(posedge clk); t++; end
    ok = (t < 20000);
    repeat (4) @(posedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(cp_en == 0, "R1 cp_en", cp_en, 0);
    chk(cp_wr == 1, "R1 cp_wr", cp_wr, 1);
    chk(done == 0, "R1 done", done, 0);
    chk(fb_we == 0, "R1 fb_we", fb_we, 0);
  endtask

  task automatic common_done(input string tag);
    chk(done_cnt == 1, {tag, " R6 done count"}, done_cnt, 1);
    chk(done_wide == 0, {tag, " R6 done width"}, done_wide, 0);
    chk(done_en == 0, {tag, " R6 enable low at done"}, done_en, 0);
    chk(done_early == 0, {tag, " R6 done after last byte"}, done_early, 0);
    chk(hold_err == 0, {tag, " R5 hold during stall"}, hold_err, 0);
  endtask

  task automatic clear_mon;
    done_cnt = 0; done_wide = 0; done_en = 0; done_early = 0; hold_err = 0;
  endtask

  task automatic t_write(input logic [31:0] a, input int mode, input bit poke, input string tag);
    int b0, r0, bad, first, k; bit ok; logic [7:0] e;
    busy_mode = mode; clear_mon();
    for (int i = 0; i < FL; i++) mem[i] = 8'((i * 13) + a[7:0] + (i >> 5));
    b0 = wn; r0 = rn;
    run_op(1'b0, a, 16 + 2*FL, poke, ok);
    chk(ok, {tag, " R2 completes"}, ok, 1);
    chk(wn - b0 == 16 + 2*FL, {tag, " R2 byte count"}, wn - b0, 16 + 2*FL);
    chk(rn == r0, {tag, " R7 no reads in writeback"}, rn - r0, 0);
    bad = 0; first = -1;
    for (int i = 0; i < 16 + 2*FL; i++) begin
      if (i < 4) e = wbyte(SYNC_W, i);
      else if (i < 8) e = wbyte(CMDW_W, i - 4);
      else if (i < 12) e = wbyte(a, i - 8);
      else if (i < 12 + FL) e = mem[i - 12];
      else if (i < 12 + 2*FL) e = 8'h00;
      else e = wbyte(DSYN_W, i - 12 - 2*FL);
      k = (b0 + i) % 8192;
      if (wlog[k] !== e) begin bad++; if (first < 0) first = i; end
    end
    chk(bad == 0, {tag, " R2 R8 stream content (mismatches, first index)"}, bad, 0);
    if (bad != 0) $display("  first mismatch at index %0d", first);
    common_done(tag);
  endtask

  task automatic t_read(input logic [31:0] a, input int mode, input string tag);
    int b0, r0, w0, bad; bit ok; logic [7:0] e;
    busy_mode = mode; clear_mon();
    for (int i = 0; i < FL; i++) mem[i] = 8'hEE;
    b0 = wn; r0 = rn; w0 = we_cnt;
    run_op(1'b1, a, 16, 1'b0, ok);
    chk(ok, {tag, " R3 completes"}, ok, 1);
    chk(wn - b0 == 16, {tag, " R3 written byte count"}, wn - b0, 16);
    chk(rn - r0 == 2*FL, {tag, " R3 read byte count"}, rn - r0, 2*FL);
    bad = 0;
    for (int i = 0; i < 16; i++) begin
      if (i < 4) e = wbyte(SYNC_W, i);
      else if (i < 8) e = wbyte(CMDR_W, i - 4);
      else if (i < 12) e = wbyte(a, i - 8);
      else e = wbyte(DSYN_W, i - 12);
      if (wlog[(b0 + i) % 8192] !== e) bad++;
    end
    chk(bad == 0, {tag, " R3 header content"}, bad, 0);
    chk(we_cnt - w0 == FL, {tag, " R4 store count, dummy dropped"}, we_cnt - w0, FL);
    bad = 0;
    for (int i = 0; i < FL; i++) if (mem[i] !== rd_pat(r0 + i)) bad++;
    chk(bad == 0, {tag, " R4 stored frame"}, bad, 0);
    common_done(tag);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1; rst = 0;
    t_reset();
    t_write(32'h0001_2345, 0, 1'b0, "wr_nostall");
    t_read (32'h00A0_0007, 0, "rd_nostall");
    t_write(32'h0042_8001, 2, 1'b0, "wr_burststall");
    t_read (32'h0300_1F00, 1, "rd_periodicstall");
    t_write(32'h0077_0055, 1, 1'b1, "wr_restart_R7");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule